// File: doc/BRIEF.md
# Subroutine Call Program Counter Unit

This block holds the 15-bit program counter of a small 8-bit microcontroller core, together with a hardware stack of return addresses. Each cycle the counter either advances by one, jumps to a call target, or is restored from the stack through a simple pop port. Instruction fetch and decode sit outside the block. The decoder presents one of three requests: an immediate call, a call through the working register, or a pop.

The two call forms build their target differently. An immediate call supplies an 11-bit field that fills the low counter bits, and the four upper bits come from the top of a separate 7-bit page latch. A working-register call places the 8-bit register value in the low byte and all seven page-latch bits above it. Either call first saves the address after the call on the stack. It then spends a second cycle in which the pipeline discards the instruction that was already fetched. The `stall_o` output marks that cycle. Stack depth, fullness and sticky overflow and underflow indications are visible at the ports.

Top module: `pc_call_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, `stall_o` is 0, `stk_empty_o` is 1, and `stk_full_o`, `stk_ovf_o` and `stk_unf_o` are 0. A two-stage synchronizer releases reset, so the first functional update happens on the third rising edge after `rst_n` rises.
- R2: When there is no stall and no request, `pc_o` increases by one on each rising edge, wrapping from 0x7FFF to 0x0000.
- R3: An accepted immediate call loads `pc_o` with {`page_i`[6:3], `imm_k_i`[10:0]} on the same edge.
- R4: An accepted working-register call loads `pc_o` with {`page_i`[6:0], `w_val_i`[7:0]} on the same edge.
- R5: Any accepted call pushes the pre-call `pc_o` plus one (modulo 2^15) onto the stack. A later pop returns these values in last-in, first-out order.
- R6: After an accepted call, `stall_o` is 1 for exactly one cycle. In that cycle `pc_o` holds the target, and all requests are ignored.
- R7: When several requests arrive in the same non-stall cycle, the immediate call wins over the working-register call, which wins over a pop.
- R8: An accepted pop on a non-empty stack loads `pc_o` with the top entry on the same edge and removes that entry. It causes no stall.
- R9: A call while 16 entries are held still loads the target and stalls. It sets `stk_ovf_o` (which stays set until reset) and leaves the depth and all stored entries unchanged.
- R10: A pop on an empty stack sets `stk_unf_o` (which stays set until reset), advances `pc_o` by one as in an idle cycle, and leaves the stack empty.
- R11: `stk_empty_o` is 1 exactly when 0 entries are held, and `stk_full_o` is 1 exactly when 16 entries are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_imm_i | input | 1 | Immediate-target call request |
| call_w_i | input | 1 | Working-register call request |
| pop_i | input | 1 | Restore counter from the top of the stack |
| imm_k_i | input | 11 | Immediate call target field |
| w_val_i | input | 8 | Working-register value |
| page_i | input | 7 | Page latch supplying the upper target bits |
| pc_o | output | 15 | Current program counter |
| stall_o | output | 1 | Second (discard) cycle of a call |
| stk_full_o | output | 1 | Stack holds 16 entries |
| stk_empty_o | output | 1 | Stack holds no entries |
| stk_ovf_o | output | 1 | Sticky: a call was made with a full stack |
| stk_unf_o | output | 1 | Sticky: a pop was made with an empty stack |

## Verification
The hardest state to reach from the ports is a full stack followed by one more call. It takes sixteen accepted calls, and each is followed by a stall cycle that ignores its inputs. A pop mixed into that stretch sets the count back. The stimulus therefore issues a long run of back-to-back calls, holding requests active through the stall cycles as well. Seventeen pops then drain the stack, so the bench can confirm that the overflowing call did not overwrite any stored return address, and can then observe underflow. Random traffic with mixed simultaneous requests follows, and a behavioural reference model with a queue is compared on every cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [1:0] {
    OP_IDLE     = 2'd0,
    OP_CALL_IMM = 2'd1,
    OP_CALL_W   = 2'd2,
    OP_RESTORE  = 2'd3
  } pcu_op_e;

endpackage

// File: rtl/pcu_rst_sync.sv
module pcu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pcu_target_mux.sv
module pcu_target_mux #(
  parameter int PC_W   = 15,
  parameter int IMM_W  = 11,
  parameter int WREG_W = 8,
  parameter int PAGE_W = 7
) (
  input  logic [IMM_W-1:0]  imm_k_i,
  input  logic [WREG_W-1:0] w_val_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PC_W-1:0]   imm_tgt_o,
  output logic [PC_W-1:0]   w_tgt_o
);

  localparam int IMM_HI_W = PC_W - IMM_W;
  localparam int W_HI_W   = PC_W - WREG_W;

  // Immediate form: the upper page-latch bits fill the top of the counter.
  assign imm_tgt_o = {page_i[PAGE_W-1 -: IMM_HI_W], imm_k_i};

  // Register form: the low page-latch bits sit directly above the low byte.
  assign w_tgt_o = {page_i[W_HI_W-1:0], w_val_i};

endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int DEPTH = 16,
  parameter int DW    = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] push_data_i,
  output logic [DW-1:0] tos_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          unf_o
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  logic             wr_en, rd_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign full_o  = (cnt_q == CNT_MAX);
  assign empty_o = (cnt_q == '0);
  assign wr_en   = push_i && !full_o;
  assign rd_en   = pop_i && !empty_o;
  assign wr_idx  = IDX_W'(cnt_q);
  assign rd_idx  = IDX_W'(cnt_q - CNT_ONE);
  assign tos_o   = mem_q[rd_idx];
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en)      cnt_d = cnt_q + CNT_ONE;
    else if (rd_en) cnt_d = cnt_q - CNT_ONE;
    ovf_d = ovf_q | (push_i & full_o);
    unf_d = unf_q | (pop_i & empty_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  // Storage carries no reset; only the write enable qualifies it.
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= push_data_i;
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  assert_ovf_keeps_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |=> (cnt_q == $past(cnt_q)) && ovf_o);

  assert_unf_keeps_depth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o) |=> empty_o && unf_o);

  assert_full_empty_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |=> unf_o);

endmodule

// File: rtl/pcu_seq.sv
module pcu_seq
  import pcu_pkg::*;
#(
  parameter int PC_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_imm_i,
  input  logic            call_w_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] imm_tgt_i,
  input  logic [PC_W-1:0] w_tgt_i,
  input  logic [PC_W-1:0] tos_i,
  input  logic            stk_empty_i,
  output logic [PC_W-1:0] pc_o,
  output logic            stall_o,
  output logic            push_o,
  output logic            pop_o,
  output logic [PC_W-1:0] ret_addr_o
);

  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  pcu_op_e         op;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc;
  logic            stall_q, stall_d;
  logic            pc_en;

  // Fixed priority; nothing is accepted in the discard cycle.
  always_comb begin
    op = OP_IDLE;
    if (!stall_q) begin
      if (call_imm_i)    op = OP_CALL_IMM;
      else if (call_w_i) op = OP_CALL_W;
      else if (pop_i)    op = OP_RESTORE;
    end
  end

  assign pc_inc = pc_q + PC_ONE;

  always_comb begin
    pc_d    = pc_inc;
    stall_d = 1'b0;
    push_o  = 1'b0;
    pop_o   = 1'b0;
    pc_en   = !stall_q;
    unique case (op)
      OP_CALL_IMM: begin
        pc_d    = imm_tgt_i;
        stall_d = 1'b1;
        push_o  = 1'b1;
      end
      OP_CALL_W: begin
        pc_d    = w_tgt_i;
        stall_d = 1'b1;
        push_o  = 1'b1;
      end
      OP_RESTORE: begin
        pop_o = 1'b1;
        pc_d  = stk_empty_i ? pc_inc : tos_i;
      end
      default: pc_d = pc_inc;
    endcase
  end

  assign ret_addr_o = pc_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      stall_q <= 1'b0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      stall_q <= stall_d;
    end
  end

  assign pc_o    = pc_q;
  assign stall_o = stall_q;

  assert_stall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !stall_o);

  assert_stall_holds_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> pc_o == $past(pc_o));

  assert_call_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && (call_imm_i || call_w_i)) |=> stall_o);

  assert_idle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && !call_imm_i && !call_w_i && !pop_i) |=> pc_o == $past(pc_o) + PC_ONE);

  assert_empty_pop_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && !call_imm_i && !call_w_i && pop_i && stk_empty_i)
      |=> pc_o == $past(pc_o) + PC_ONE);

  assert_pop_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && !call_imm_i && !call_w_i && pop_i) |=> !stall_o);

  assert_push_pop_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_o && pop_o));

endmodule

// File: rtl/pc_call_unit.sv
module pc_call_unit #(
  parameter int PC_W   = 15,
  parameter int IMM_W  = 11,
  parameter int WREG_W = 8,
  parameter int PAGE_W = 7,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_imm_i,
  input  logic              call_w_i,
  input  logic              pop_i,
  input  logic [IMM_W-1:0]  imm_k_i,
  input  logic [WREG_W-1:0] w_val_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              stall_o,
  output logic              stk_full_o,
  output logic              stk_empty_o,
  output logic              stk_ovf_o,
  output logic              stk_unf_o
);

  localparam int IMM_HI_W = PC_W - IMM_W;

  logic            rst_int_n;
  logic [PC_W-1:0] imm_tgt, w_tgt, tos, ret_addr;
  logic            push, pop;

  pcu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pcu_target_mux #(
    .PC_W(PC_W), .IMM_W(IMM_W), .WREG_W(WREG_W), .PAGE_W(PAGE_W)
  ) u_tgt (
    .imm_k_i   (imm_k_i),
    .w_val_i   (w_val_i),
    .page_i    (page_i),
    .imm_tgt_o (imm_tgt),
    .w_tgt_o   (w_tgt)
  );

  pcu_seq #(.PC_W(PC_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .call_imm_i  (call_imm_i),
    .call_w_i    (call_w_i),
    .pop_i       (pop_i),
    .imm_tgt_i   (imm_tgt),
    .w_tgt_i     (w_tgt),
    .tos_i       (tos),
    .stk_empty_i (stk_empty_o),
    .pc_o        (pc_o),
    .stall_o     (stall_o),
    .push_o      (push),
    .pop_o       (pop),
    .ret_addr_o  (ret_addr)
  );

  pcu_ret_stack #(.DEPTH(DEPTH), .DW(PC_W)) u_stk (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (ret_addr),
    .tos_o       (tos),
    .full_o      (stk_full_o),
    .empty_o     (stk_empty_o),
    .ovf_o       (stk_ovf_o),
    .unf_o       (stk_unf_o)
  );

  // Target checks at the ports, across the mux and the sequencer.
  assert_imm_target_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!stall_o && call_imm_i)
      |=> pc_o == {$past(page_i[PAGE_W-1 -: IMM_HI_W]), $past(imm_k_i)});

  assert_w_target_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!stall_o && !call_imm_i && call_w_i)
      |=> pc_o[WREG_W-1:0] == $past(w_val_i));

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_int_n |-> (pc_o == '0) && !stall_o && stk_empty_o && !stk_ovf_o && !stk_unf_o);

endmodule

// File: tb/sim_pc_call_unit.sv
module sim_pc_call_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_imm, call_w, pop;
  logic [10:0] imm_k;
  logic [7:0]  w_val;
  logic [6:0]  page;
  logic [14:0] pc;
  logic        stall, full, empty, ovf, unf;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Reference model state
  int m_pc    = 0;
  bit m_stall = 0;
  bit m_ovf   = 0;
  bit m_unf   = 0;
  int m_stk[$];

  always #2 clk = ~clk;

  pc_call_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .call_imm_i(call_imm), .call_w_i(call_w), .pop_i(pop),
    .imm_k_i(imm_k), .w_val_i(w_val), .page_i(page),
    .pc_o(pc), .stall_o(stall),
    .stk_full_o(full), .stk_empty_o(empty),
    .stk_ovf_o(ovf), .stk_unf_o(unf)
  );

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One clock: drive at the negedge, step the model, compare after the edge.
  task automatic cycle(input bit ci, input bit cw, input bit cp,
                       input int k, input int wv, input int pg);
    string ptag, ftag;
    int    e_full, e_empty, flags_act, flags_exp;
    call_imm = ci; call_w = cw; pop = cp;
    imm_k = 11'(k); w_val = 8'(wv); page = 7'(pg);
    ftag = "R11";
    @(posedge clk);
    if (m_stall) begin
      m_stall = 0;
      ptag = (ci || cw || cp) ? "R6 ignore" : "R6";
    end else if (ci || cw) begin
      if (int'(ci) + int'(cw) + int'(cp) > 1) ptag = "R7";
      else ptag = ci ? "R3" : "R4";
      if (m_stk.size() < 16) m_stk.push_back((m_pc + 1) & 32'h7fff);
      else begin m_ovf = 1; ftag = "R9"; ptag = "R9"; end
      if (ci) m_pc = ((pg >> 3) & 15) << 11 | (k & 32'h7ff);
      else    m_pc = (pg & 127) << 8 | (wv & 255);
      m_stall = 1;
    end else if (cp) begin
      if (m_stk.size() > 0) begin
        m_pc = m_stk.pop_back();
        ptag = "R5 R8";
      end else begin
        m_unf = 1;
        m_pc = (m_pc + 1) & 32'h7fff;
        ptag = "R10"; ftag = "R10";
      end
    end else begin
      m_pc = (m_pc + 1) & 32'h7fff;
      ptag = "R2";
    end
    #1;
    check(ptag, (pc === 15'(m_pc)) && (stall === m_stall),
          {15'b0, stall, pc}, {15'b0, m_stall, 15'(m_pc)});
    e_full  = (m_stk.size() == 16);
    e_empty = (m_stk.size() == 0);
    flags_act = {full, empty, ovf, unf};
    flags_exp = {e_full[0], e_empty[0], m_ovf, m_unf};
    check(ftag, flags_act == flags_exp, flags_act, flags_exp);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    call_imm = 0; call_w = 0; pop = 0; imm_k = '0; w_val = '0; page = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: values held in reset, with requests present
    call_imm = 1; imm_k = 11'h7ff; page = 7'h7f;
    @(posedge clk); #1;
    check("R1", {pc, stall, full, empty, ovf, unf} === {15'h0, 5'b00100},
          {pc, stall, full, empty, ovf, unf}, {15'h0, 5'b00100});
    @(negedge clk);
    call_imm = 0; imm_k = '0; page = '0;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 sync", pc === 15'h0 && stall === 1'b0, pc, 0);
    @(negedge clk);

    idle(4);                                   // R2
    cycle(1, 0, 0, 'h123, 0, 'h55);            // R3 -> 0x5123
    cycle(0, 1, 1, 0, 'h99, 'h11);             // R6: ignored in stall
    idle(2);
    cycle(0, 1, 0, 0, 'h3c, 'h12);             // R4 -> 0x123C
    idle(1);
    cycle(0, 0, 1, 0, 0, 0);                   // R5 R8
    cycle(0, 0, 1, 0, 0, 0);                   // R5 R8
    cycle(0, 0, 1, 0, 0, 0);                   // R10 underflow
    idle(1);
    cycle(1, 1, 1, 'h2aa, 'h77, 'h6b);         // R7: immediate wins
    idle(1);
    cycle(0, 1, 1, 'h155, 'h88, 'h2c);         // R7: register call wins
    idle(1);
    cycle(0, 0, 1, 0, 0, 0);
    cycle(0, 0, 1, 0, 0, 0);
    cycle(0, 1, 0, 0, 'hff, 'h7f);             // R4 -> 0x7FFF
    idle(3);                                   // R2 wrap to 0
    for (int i = 0; i < 18; i++) begin         // R9: fill past 16
      cycle(1, 0, 0, i * 97, 0, i * 9);
      cycle(1, 1, 1, 'h7ff, 'hff, 'h7f);       // stall cycle, ignored
    end
    for (int i = 0; i < 17; i++) cycle(0, 0, 1, 0, 0, 0);  // LIFO then R10
    idle(2);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      cycle(r < 12, (r >= 8) && (r < 22), (r >= 18) && (r < 40),
            $urandom_range(0, 2047), $urandom_range(0, 255), $urandom_range(0, 127));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule